// File: doc/BRIEF.md
# Serial ADC Acquisition Controller

This block is the host end of a link to an external 8-bit successive-approximation converter that has a three-wire serial control port. A single request pulse carries a channel configuration: single-ended or differential, an odd/even polarity bit and the channel select bits. The controller then frames one complete conversion. It lowers chip select and runs a serial clock divided down from the system clock. It shifts out a start bit followed by the configuration word, and it skips the one-bit settling slot that the converter inserts. It then collects the result twice: once most-significant-bit first, and once least-significant-bit first with the LSB not repeated.

When the frame ends, chip select goes high. The byte read MSB first is presented with a one-cycle valid strobe. An error flag is raised with the strobe whenever the byte rebuilt from the LSB-first stream disagrees with it. A parameter selects the 3-bit or the 4-bit configuration word, which covers the 4-channel and the 8-channel converter variants. A second parameter selects single-wire operation. In that mode the data-in and data-out lines share one pad, and the controller drives the pad only while it sends the configuration.

Top module: `adc_serial_reader`

## Requirements
- R1: Out of reset, chip select is high, the serial clock is low and the valid strobe is low. `ready` stays low for CS_HIGH_CYC system cycles and then rises.
- R2: An accepted request drops chip select in the same cycle. The first serial clock rise comes HALF_DIV system cycles later, and each later half period lasts HALF_DIV cycles. The serial clock is never high while chip select is high.
- R3: The data-in line carries a 1 start bit, followed by the mode bit (1 = single-ended), the odd/even bit and then the select bits, most significant first. This is 3 bits after the start bit when ADDR_BITS=3 (only select bit 0 is sent) and 4 bits when ADDR_BITS=4. The line changes only on falling serial clock edges.
- R4: The bit in the slot that follows the last configuration bit is discarded, whatever level it has.
- R5: `rd_data` is the 8 bits sampled on the next 8 rising edges, first sample in bit 7.
- R6: The next 7 rising edges sample result bits 1 to 7 in that order. `rd_err` is 1 exactly when they differ from bits 1 to 7 of `rd_data`.
- R7: A frame contains ADDR_BITS+17 serial clock rises. On the falling edge that closes it, chip select rises and `rd_valid` pulses for a single cycle in the same cycle, together with `rd_data` and `rd_err`.
- R8: `ready` is low during a frame and for CS_HIGH_CYC cycles after chip select rises. Requests made while `ready` is low are ignored, so chip select stays high for at least CS_HIGH_CYC cycles between frames.
- R9: With SINGLE_WIRE=1, `adc_di_oe` is high only during the configuration slots and is low before the converter starts driving. With SINGLE_WIRE=0 it is always high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Request pulse; taken when `ready` is high |
| req_single | input | 1 | 1 = single-ended, 0 = differential |
| req_odd | input | 1 | Odd/even polarity bit |
| req_sel | input | ADDR_BITS-2 | Channel select bits |
| ready | output | 1 | Idle and chip-select high time satisfied |
| rd_valid | output | 1 | One-cycle result strobe |
| rd_data | output | DATA_W | Result, captured MSB first |
| rd_err | output | 1 | MSB-first and LSB-first copies disagree |
| adc_cs_n | output | 1 | Converter chip select, active low |
| adc_sclk | output | 1 | Serial clock to the converter |
| adc_di | output | 1 | Configuration data to the converter |
| adc_di_oe | output | 1 | Pad drive enable for `adc_di` |
| adc_do | input | 1 | Converter data (the shared pad in single-wire mode) |

## Verification
The hardest case to reach from the ports is a disagreement between the two copies of the result, because a working converter never produces one. The bench therefore models the converter with an error mask that flips chosen bits of its LSB-first stream only, including the unrepeated LSB, whose flip must raise no error. The same model drives the inverse of the MSB into the settling slot, so that an off-by-one capture shows up in the data. In single-wire mode the pad is modelled as one resolved line, and the bench looks for any cycle in which both sides drive it.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

  typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} rd_state_e;

  // Configuration word, left aligned: start, mode, odd/even, select bits.
  function automatic logic [4:0] addr_word(input logic single, input logic odd,
                                           input logic [1:0] sel, input int abits);
    if (abits == 4) return {1'b1, single, odd, sel};
    return {1'b1, single, odd, sel[0], 1'b0};
  endfunction

  // Serial clock periods in one frame: start + config + settle + MSB run + LSB run.
  function automatic int frame_slots(input int abits, input int dw);
    return abits + 1 + 1 + dw + (dw - 1);
  endfunction

endpackage

// File: rtl/adc_rd_clkdiv.sv
module adc_rd_clkdiv #(
  parameter int HALF_DIV = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic sclk,
  output logic rise_tick,
  output logic fall_tick
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [CW-1:0] cnt;
  logic          term;

  assign term      = run && (cnt == CW'(HALF_DIV - 1));
  assign rise_tick = term && !sclk;
  assign fall_tick = term && sclk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      sclk <= 1'b0;
    end else if (!run) begin
      cnt  <= '0;
      sclk <= 1'b0;
    end else if (term) begin
      cnt  <= '0;
      sclk <= ~sclk;
    end else begin
      cnt  <= cnt + 1'b1;
    end
  end

  // R2
  sclk_rest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !sclk);

endmodule

// File: rtl/adc_rd_guard.sv
module adc_rd_guard #(
  parameter int CS_HIGH_CYC = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  output logic hold_ok
);
  localparam int CW = $clog2(CS_HIGH_CYC + 1);

  logic [CW-1:0] cnt;

  assign hold_ok = (cnt == CW'(CS_HIGH_CYC));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (!cs_n)    cnt <= '0;
    else if (!hold_ok) cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/adc_rd_rx.sv
module adc_rd_rx #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              take_msb,
  input  logic              take_lsb,
  input  logic              din,
  output logic [DATA_W-1:0] msb_byte,
  output logic [DATA_W-1:0] lsb_byte,
  output logic              mismatch
);
  logic [DATA_W-1:0] msb_sr;
  logic [DATA_W-2:0] lsb_sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msb_sr <= '0;
      lsb_sr <= '0;
    end else if (clear) begin
      msb_sr <= '0;
      lsb_sr <= '0;
    end else if (take_msb) begin
      msb_sr <= {msb_sr[DATA_W-2:0], din};
    end else if (take_lsb) begin
      lsb_sr <= {din, lsb_sr[DATA_W-2:1]};
    end
  end

  // LSB is sent only once, so the reversed copy borrows it from the MSB run.
  assign msb_byte = msb_sr;
  assign lsb_byte = {lsb_sr, msb_sr[0]};
  assign mismatch = (lsb_byte != msb_byte);

  // R6
  take_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(take_msb && take_lsb));

endmodule

// File: rtl/adc_serial_reader.sv
module adc_serial_reader
  import adc_rd_pkg::*;
#(
  parameter int HALF_DIV    = 200,
  parameter int CS_HIGH_CYC = 40,
  parameter int ADDR_BITS   = 4,
  parameter int DATA_W      = 8,
  parameter bit SINGLE_WIRE = 1'b0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req,
  input  logic                 req_single,
  input  logic                 req_odd,
  input  logic [ADDR_BITS-3:0] req_sel,
  output logic                 ready,
  output logic                 rd_valid,
  output logic [DATA_W-1:0]    rd_data,
  output logic                 rd_err,
  output logic                 adc_cs_n,
  output logic                 adc_sclk,
  output logic                 adc_di,
  output logic                 adc_di_oe,
  input  logic                 adc_do
);
  localparam int N_ADDR  = ADDR_BITS + 1;
  localparam int N_SLOTS = frame_slots(ADDR_BITS, DATA_W);
  localparam int SLOT_W  = $clog2(N_SLOTS);
  localparam int MSB_LO  = N_ADDR + 1;
  localparam int MSB_HI  = N_ADDR + DATA_W;
  localparam int LAST    = N_SLOTS - 1;

  rd_state_e         state;
  logic [SLOT_W-1:0] slot;
  logic [N_ADDR-1:0] word_sr;
  logic              running, accept, hold_ok;
  logic              rise_tick, fall_tick, last_fall;
  logic              in_msb, in_lsb, take_msb, take_lsb;
  logic [DATA_W-1:0] msb_byte, lsb_byte;
  logic              mismatch;
  logic [1:0]        sel2;
  logic [4:0]        aw;

  assign running   = (state == ST_RUN);
  assign ready     = (state == ST_IDLE) && hold_ok;
  assign accept    = req && ready;
  assign sel2      = 2'(req_sel);
  assign aw        = addr_word(req_single, req_odd, sel2, ADDR_BITS);
  assign in_msb    = (slot >= SLOT_W'(MSB_LO)) && (slot <= SLOT_W'(MSB_HI));
  assign in_lsb    = (slot >  SLOT_W'(MSB_HI));
  assign take_msb  = rise_tick && in_msb;
  assign take_lsb  = rise_tick && in_lsb;
  assign last_fall = fall_tick && (slot == SLOT_W'(LAST));
  assign adc_di    = word_sr[N_ADDR-1];

  generate
    if (SINGLE_WIRE) begin : g_shared
      assign adc_di_oe = running && (slot < SLOT_W'(N_ADDR));
    end else begin : g_split
      assign adc_di_oe = 1'b1;
    end
  endgenerate

  adc_rd_clkdiv #(.HALF_DIV(HALF_DIV)) u_div (
    .clk(clk), .rst_n(rst_n), .run(running),
    .sclk(adc_sclk), .rise_tick(rise_tick), .fall_tick(fall_tick)
  );

  adc_rd_guard #(.CS_HIGH_CYC(CS_HIGH_CYC)) u_guard (
    .clk(clk), .rst_n(rst_n), .cs_n(adc_cs_n), .hold_ok(hold_ok)
  );

  adc_rd_rx #(.DATA_W(DATA_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .clear(accept),
    .take_msb(take_msb), .take_lsb(take_lsb), .din(adc_do),
    .msb_byte(msb_byte), .lsb_byte(lsb_byte), .mismatch(mismatch)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      slot     <= '0;
      word_sr  <= '0;
      adc_cs_n <= 1'b1;
      rd_valid <= 1'b0;
      rd_data  <= '0;
      rd_err   <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      case (state)
        ST_IDLE: if (accept) begin
          state    <= ST_RUN;
          slot     <= '0;
          word_sr  <= aw[4 -: N_ADDR];
          adc_cs_n <= 1'b0;
        end
        ST_RUN: if (fall_tick) begin
          word_sr <= word_sr << 1;
          if (last_fall) begin
            state    <= ST_IDLE;
            slot     <= '0;
            adc_cs_n <= 1'b1;
            rd_valid <= 1'b1;
            rd_data  <= msb_byte;
            rd_err   <= mismatch;
          end else begin
            slot <= slot + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2
  cs_framed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adc_sclk |-> !adc_cs_n);
  // R3
  di_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adc_sclk && $past(adc_sclk)) |-> $stable(adc_di));
  // R7
  valid_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $rose(adc_cs_n));
  // R7
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);
  // R8
  cs_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(adc_cs_n) |-> $past(hold_ok));
  // R9
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take_msb || take_lsb) |-> (!SINGLE_WIRE || !adc_di_oe));

endmodule

// File: tb/sim_adc_serial_reader.sv
module adc_model #(
  parameter int ABITS = 4,
  parameter int DW    = 8
) (
  input  logic             clk,
  input  logic             cs_n,
  input  logic             sclk,
  input  logic             din,
  input  logic [DW-1:0]    value,
  input  logic [DW-1:0]    corrupt,
  input  logic             settle_val,
  output logic             dout,
  output logic             dout_en,
  output logic [ABITS-1:0] got_addr,
  output int               rises,
  output int               cs_falls
);
  logic prev_cs = 1'b1, prev_sck = 1'b0, started = 1'b0;
  logic [ABITS-1:0] addr = '0;
  int ac = 0, oidx = 0, rc = 0, nf = 0;

  initial begin
    dout = 1'b1; dout_en = 1'b0; got_addr = '0; rises = 0; cs_falls = 0;
  end

  always @(negedge clk) begin
    if (cs_n) begin
      dout_en <= 1'b0;
    end else begin
      if (prev_cs) begin
        started = 1'b0; ac = 0; oidx = 0; addr = '0; rc = 0; nf++;
      end
      if (sclk && !prev_sck) begin
        rc++;
        if (!started) started = din;
        else if (ac < ABITS) begin addr = {addr[ABITS-2:0], din}; ac++; end
      end
      if (!sclk && prev_sck && ac == ABITS) begin
        dout_en <= 1'b1;
        if (oidx == 0)       dout <= settle_val;
        else if (oidx <= DW) dout <= value[DW-oidx];
        else if (oidx < 2*DW) dout <= value[oidx-DW] ^ corrupt[oidx-DW];
        else                 dout <= 1'b0;
        oidx++;
      end
    end
    prev_cs = cs_n; prev_sck = sclk;
    got_addr <= addr; rises <= rc; cs_falls <= nf;
  end
endmodule

module sim_adc_serial_reader;
  localparam int CLK_NS = 10;
  localparam int HD0 = 3, CSH0 = 6, HD1 = 2, CSH1 = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  always #(CLK_NS/2) clk = ~clk;

  int checks = 0, errs = 0;
  logic       req_r [2], sgl_r [2], odd_r [2];
  logic [1:0] sel_r [2];
  logic [7:0] val_m [2], cor_m [2];

  logic rdy0, vld0, err0, cs0, sck0, di0, oe0, mdo0, men0;
  logic rdy1, vld1, err1, cs1, sck1, di1, oe1, mdo1, men1, line1, do0;
  logic [7:0] dat0, dat1;
  logic [3:0] ma0; logic [2:0] ma1;
  int rs0, rs1, cf0, cf1;

  assign do0   = men0 ? mdo0 : 1'b1;
  assign line1 = oe1 ? di1 : (men1 ? mdo1 : 1'b1);

  adc_serial_reader #(.HALF_DIV(HD0), .CS_HIGH_CYC(CSH0), .ADDR_BITS(4),
                      .DATA_W(8), .SINGLE_WIRE(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .req(req_r[0]), .req_single(sgl_r[0]),
    .req_odd(odd_r[0]), .req_sel(sel_r[0]), .ready(rdy0), .rd_valid(vld0),
    .rd_data(dat0), .rd_err(err0), .adc_cs_n(cs0), .adc_sclk(sck0),
    .adc_di(di0), .adc_di_oe(oe0), .adc_do(do0));

  adc_model #(.ABITS(4), .DW(8)) m0 (
    .clk(clk), .cs_n(cs0), .sclk(sck0), .din(di0), .value(val_m[0]),
    .corrupt(cor_m[0]), .settle_val(~val_m[0][7]), .dout(mdo0),
    .dout_en(men0), .got_addr(ma0), .rises(rs0), .cs_falls(cf0));

  adc_serial_reader #(.HALF_DIV(HD1), .CS_HIGH_CYC(CSH1), .ADDR_BITS(3),
                      .DATA_W(8), .SINGLE_WIRE(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .req(req_r[1]), .req_single(sgl_r[1]),
    .req_odd(odd_r[1]), .req_sel(sel_r[1][0:0]), .ready(rdy1), .rd_valid(vld1),
    .rd_data(dat1), .rd_err(err1), .adc_cs_n(cs1), .adc_sclk(sck1),
    .adc_di(di1), .adc_di_oe(oe1), .adc_do(line1));

  adc_model #(.ABITS(3), .DW(8)) m1 (
    .clk(clk), .cs_n(cs1), .sclk(sck1), .din(line1), .value(val_m[1]),
    .corrupt(cor_m[1]), .settle_val(~val_m[1][7]), .dout(mdo1),
    .dout_en(men1), .got_addr(ma1), .rises(rs1), .cs_falls(cf1));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Drive-conflict and enable monitors (R9), CS high time (R8).
  int clash [2], oe_bad, hi0 = 0, hi1 = 0;
  bit seen0 = 0, seen1 = 0;
  always @(negedge clk) if (rst_n) begin
    if (oe1 && men1) clash[1]++;
    if (!oe0) oe_bad++;
    if (cs0) hi0++; else begin
      if (seen0 && hi0 > 0) check(hi0 >= CSH0, "R8 cs0 high time", hi0, CSH0);
      if (hi0 > 0) seen0 = 1; hi0 = 0;
    end
    if (cs1) hi1++; else begin
      if (seen1 && hi1 > 0) check(hi1 >= CSH1, "R8 cs1 high time", hi1, CSH1);
      if (hi1 > 0) seen1 = 1; hi1 = 0;
    end
  end

  function automatic logic rdy_of(input int w); return w == 0 ? rdy0 : rdy1; endfunction
  function automatic logic vld_of(input int w); return w == 0 ? vld0 : vld1; endfunction
  function automatic logic cs_of (input int w); return w == 0 ? cs0  : cs1;  endfunction
  function automatic logic sck_of(input int w); return w == 0 ? sck0 : sck1; endfunction
  function automatic int   cf_of (input int w); return w == 0 ? cf0  : cf1;  endfunction

  task automatic frame(input int w, input logic s, input logic o, input logic [1:0] sel,
                       input logic [7:0] v, input logic [7:0] cor, input bit poke);
    int k, hd, cf_start, exp_rises, csh;
    logic [3:0] exp_addr, got;
    hd = (w == 0) ? HD0 : HD1;
    csh = (w == 0) ? CSH0 : CSH1;
    exp_rises = (w == 0) ? 21 : 20;
    exp_addr = (w == 0) ? {s, o, sel} : {1'b0, s, o, sel[0]};
    val_m[w] = v; cor_m[w] = cor; clash[w] = 0;
    while (!rdy_of(w)) @(negedge clk);
    cf_start = cf_of(w);
    req_r[w] = 1'b1; sgl_r[w] = s; odd_r[w] = o; sel_r[w] = sel;
    @(negedge clk);
    req_r[w] = 1'b0;
    check(cs_of(w) == 1'b0, "R2 cs low after accept", cs_of(w), 0);
    check(rdy_of(w) == 1'b0, "R8 ready low while busy", rdy_of(w), 0);
    k = 0;
    while (!sck_of(w)) begin @(negedge clk); k++; end
    check(k == hd, "R2 first rise delay", k, hd);
    if (poke) begin
      req_r[w] = 1'b1; sgl_r[w] = ~s; odd_r[w] = ~o; sel_r[w] = ~sel;
      @(negedge clk);
      req_r[w] = 1'b0;
    end
    while (!vld_of(w)) @(negedge clk);
    got = (w == 0) ? ma0 : {1'b0, ma1};
    check(got == exp_addr, "R3 config word", got, exp_addr);
    check(((w == 0) ? dat0 : dat1) == v, "R5 data", (w == 0) ? dat0 : dat1, v);
    check(((w == 0) ? dat0[7] : dat1[7]) == v[7], "R4 settle slot dropped",
          (w == 0) ? dat0[7] : dat1[7], v[7]);
    check(((w == 0) ? err0 : err1) == (|cor[7:1]), "R6 mismatch flag",
          (w == 0) ? err0 : err1, |cor[7:1]);
    check(((w == 0) ? rs0 : rs1) == exp_rises, "R7 rises per frame",
          (w == 0) ? rs0 : rs1, exp_rises);
    check(cs_of(w) == 1'b1, "R7 cs high with valid", cs_of(w), 1);
    check(cf_of(w) == cf_start + 1, "R8 one frame per request", cf_of(w), cf_start + 1);
    if (w == 1) check(clash[1] == 0, "R9 pad contention", clash[1], 0);
    @(negedge clk);
    check(vld_of(w) == 1'b0, "R7 valid one cycle", vld_of(w), 0);
    if (poke) begin
      // Request during the CS-high hold must be dropped.
      check(rdy_of(w) == 1'b0, "R8 ready low in hold", rdy_of(w), 0);
      req_r[w] = 1'b1;
      @(negedge clk);
      req_r[w] = 1'b0;
      repeat (csh + 3) @(negedge clk);
      check(cs_of(w) == 1'b1 && cf_of(w) == cf_start + 1, "R8 held-off request ignored",
            cf_of(w), cf_start + 1);
    end
  endtask

  initial begin
    for (int i = 0; i < 2; i++) begin
      req_r[i] = 0; sgl_r[i] = 0; odd_r[i] = 0; sel_r[i] = 0; val_m[i] = 0; cor_m[i] = 0;
      clash[i] = 0;
    end
    oe_bad = 0;
    repeat (3) @(negedge clk);
    check(cs0 && cs1, "R1 cs high in reset", cs0 & cs1, 1);
    check(!sck0 && !sck1, "R1 sclk low in reset", sck0 | sck1, 0);
    rst_n = 1'b1;
    repeat (CSH1 - 1) @(negedge clk);
    check(!rdy0 && !rdy1 && !vld0 && !vld1, "R1 ready held after reset", rdy0 | rdy1, 0);
    @(negedge clk);
    check(rdy1 == 1'b1, "R1 ready after hold (u1)", rdy1, 1);
    @(negedge clk);
    check(rdy0 == 1'b1, "R1 ready after hold (u0)", rdy0, 1);

    for (int a = 0; a < 16; a++) begin
      frame(0, a[3], a[2], a[1:0], 8'(a * 37 + 11), 8'h00, 1'b0);
      frame(0, a[3], a[2], a[1:0], ~8'(a * 37 + 11), 8'h00, 1'b0);
    end
    frame(0, 1'b1, 1'b0, 2'd2, 8'h00, 8'h00, 1'b0);
    frame(0, 1'b1, 1'b1, 2'd3, 8'hFF, 8'h00, 1'b0);
    frame(0, 1'b0, 1'b1, 2'd1, 8'h5A, 8'h02, 1'b0);
    frame(0, 1'b0, 1'b0, 2'd0, 8'hC3, 8'h80, 1'b0);
    frame(0, 1'b1, 1'b0, 2'd1, 8'h3C, 8'h01, 1'b0);
    frame(0, 1'b0, 1'b1, 2'd2, 8'h96, 8'h00, 1'b1);
    check(oe_bad == 0, "R9 two-wire enable always high", oe_bad, 0);

    for (int a = 0; a < 8; a++) begin
      frame(1, a[2], a[1], {1'b0, a[0]}, 8'(a * 29 + 3), 8'h00, 1'b0);
      frame(1, a[2], a[1], {1'b0, a[0]}, 8'(a * 29 + 3) ^ 8'h81, 8'h00, 1'b0);
    end
    frame(1, 1'b1, 1'b0, 2'd1, 8'hA5, 8'h40, 1'b0);
    frame(1, 1'b0, 1'b1, 2'd0, 8'h7E, 8'h01, 1'b1);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #(CLK_NS * 150000);
    errs++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule